// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves data between the endpoint FIFOs of a USB controller and system memory, on eight independent channels. Software programs each channel through a small register window. It writes a memory address and a byte count, then writes the control word. The control word carries the enable bit, the direction, an interrupt enable, the endpoint number and the burst type. Writing the control word with enable set starts the channel.

A running channel asks for the shared memory master port. Channels take the port in turn, one burst at a time. Each beat moves one 32-bit word. On a transmit channel the beat is a memory read whose data goes to the endpoint port. On a receive channel, data taken from the endpoint port is written to memory. The channel's address register moves forward as the data moves, so software finds the number of bytes transferred by subtracting the start address from the current address.

When the count reaches zero, or when the memory port reports an error, the channel stops. It can then raise its flag in a shared interrupt status byte. The irq output is high while any flag is set.

Top module: `dma_ep_engine`

## Requirements
- R1: Channel n's registers sit at byte address 0x200 + 16·n: control at +0x4 (bits: 0 enable, 1 transmit, 2 mode, 3 interrupt enable, 7:4 endpoint, 8 bus error, 10:9 burst type), address at +0x8 and count at +0xC. A read returns the stored value one cycle after the read strobe. Any write to control clears bit 8.
- R2: A control write with bit 0 set starts the channel. The channel then issues beats on the memory port (mem_valid high), and the first beat carries the programmed address.
- R3: Each beat moves min(4, count) bytes. The count drops by that amount and the address rises by that amount, so after a transfer the address equals start + bytes. The last beat of a transfer whose length is not a multiple of 4 has strobe bits set only for the valid low bytes (1→0001, 2→0011, 3→0111).
- R4: The burst type selects 1, 4, 8 or 16 beats per burst (codes 0 to 3). mem_len gives the beats of the current burst minus one. A burst is shortened to the remaining words, and mem_burst shows the channel's type code.
- R5: When the count reaches zero, enable clears. The channel's interrupt flag is set only if interrupt enable is set.
- R6: Reading byte address 0x200 returns the flags (bit n for channel n) and clears the flags it returned. irq is high exactly while some flag is set.
- R7: If mem_err is high on an accepted beat, that beat is discarded. The channel sets control bit 8, clears enable, raises its flag whatever its interrupt enable, and issues no further beats.
- R8: Writing control with bit 0 clear stops a running channel. No beat of that channel follows, and no completion flag is raised.
- R9: When several channels are ready, they take the memory port in round-robin order, one burst each, starting after the last granted channel.
- R10: On a transmit channel, memory read data goes to the endpoint port in the beat cycle, with ep_num equal to the channel's endpoint field. On a receive channel, endpoint data is written to memory (mem_write high), and each endpoint word is taken in the same cycle as its memory beat.
- R11: The count register holds 17 bits (transfers up to 0x10000 bytes). Higher written bits are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| irq | output | 1 | High while any interrupt flag is set |
| mem_valid | output | 1 | Beat request on the memory port |
| mem_write | output | 1 | 1 = memory write (receive), 0 = memory read (transmit) |
| mem_addr | output | 32 | Beat byte address |
| mem_strb | output | 4 | Byte strobes of the beat |
| mem_len | output | 4 | Beats in the current burst minus one |
| mem_burst | output | 2 | Burst type code of the owning channel |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat accepted (read data valid in the same cycle) |
| mem_err | input | 1 | Bus error on the accepted beat |
| mem_rdata | input | 32 | Read data |
| ep_num | output | 4 | Endpoint number of the owning channel |
| ep_tx | output | 1 | Direction of the owning channel |
| ep_wvalid | output | 1 | Word to the endpoint FIFO is valid |
| ep_wdata | output | 32 | Word to the endpoint FIFO |
| ep_strb | output | 4 | Byte strobes of that word |
| ep_wready | input | 1 | Endpoint FIFO can take a word |
| ep_rvalid | input | 1 | Endpoint FIFO offers a word |
| ep_rdata | input | 32 | Word from the endpoint FIFO |
| ep_rready | output | 1 | Word from the endpoint FIFO is taken |

## Verification
The hardest case to reach is several channels ready at the same burst boundary. A channel that starts alone grabs the idle port at once. The stimulus therefore holds mem_ready low while three channels are programmed, so that all of them wait together behind the first burst. It then checks the endpoint numbers of the beats in order. Two other cases need targeted stimulus. A bus error on one chosen beat is injected by matching the beat address. An abort in the middle of a burst is made by rewriting the control register while a long transfer is running. Random single-channel transfers vary the length, burst type and direction, and are checked against expected beat lists that the bench computes.

// File: rtl/dma_ep_pkg.sv
package dma_ep_pkg;

    // Control word; packed field order matches the register bit layout.
    typedef struct packed {
        logic [1:0] burst;
        logic       berr;
        logic [3:0] ep;
        logic       ie;
        logic       mode;
        logic       tx;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        MV_IDLE  = 1'b0,
        MV_BURST = 1'b1
    } mv_state_e;

    function automatic logic [4:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd1:    burst_beats = 5'd4;
            2'd2:    burst_beats = 5'd8;
            2'd3:    burst_beats = 5'd16;
            default: burst_beats = 5'd1;
        endcase
    endfunction

    function automatic logic [3:0] strb_for(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    strb_for = 4'b0001;
            3'd2:    strb_for = 4'b0011;
            3'd3:    strb_for = 4'b0111;
            default: strb_for = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dma_ep_chan.sv
module dma_ep_chan
    import dma_ep_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [31:0]       wdata,
    input  logic              beat_hit,
    input  logic [2:0]        beat_step,
    input  logic              err_hit,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              req,
    output logic              flag_set
);

    logic finishing;
    assign finishing = ctrl.en && (cnt == '0) && !wr_ctrl && !err_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            addr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_addr)
                addr <= wdata[ADDR_W-1:0];
            else if (beat_hit)
                addr <= addr + ADDR_W'(beat_step);

            if (wr_cnt)
                cnt <= wdata[CNT_W-1:0];
            else if (beat_hit)
                cnt <= cnt - CNT_W'(beat_step);

            if (wr_ctrl) begin
                ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
                ctrl.berr <= 1'b0;
            end else if (err_hit) begin
                ctrl.en   <= 1'b0;
                ctrl.berr <= 1'b1;
            end else if (finishing) begin
                ctrl.en   <= 1'b0;
            end
        end
    end

    assign req      = ctrl.en && (cnt != '0);
    assign flag_set = (err_hit && !wr_ctrl) || (finishing && ctrl.ie);

    // R5: a channel with nothing left to move drops its enable
    assert_done_clears_en_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && cnt == '0 && !wr_ctrl) |=> !ctrl.en);

    // R7: an error beat leaves the channel stopped with the error bit set
    assert_err_marks_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
        (err_hit && !wr_ctrl) |=> (ctrl.berr && !ctrl.en));

    // R3: without a software write the count only goes down
    assert_cnt_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/dma_ep_rr_arb.sv
module dma_ep_rr_arb #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);

    logic [IDX_W-1:0] ptr;

    always_comb begin
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[ptr + IDX_W'(i)]) begin
                gnt_idx = ptr + IDX_W'(i);
                any     = 1'b1;
            end
        end
        gnt = any ? (N'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (take && any)
            ptr <= gnt_idx + IDX_W'(1);
    end

    // R9: at most one grant, and only to a requester
    assert_gnt_valid_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/dma_ep_mover.sv
module dma_ep_mover
    import dma_ep_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 17,
    parameter int IDX_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any,
    input  logic [IDX_W-1:0]  gnt_idx,
    input  ctrl_t             ctrl_arr [NCH],
    input  logic [ADDR_W-1:0] addr_arr [NCH],
    input  logic [CNT_W-1:0]  cnt_arr  [NCH],
    output logic              take,
    output logic [NCH-1:0]    beat_hit,
    output logic [2:0]        beat_step,
    output logic [NCH-1:0]    err_hit,
    output logic [IDX_W-1:0]  cur_ch,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_strb,
    output logic [3:0]        mem_len,
    output logic [1:0]        mem_burst,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic [3:0]        ep_num,
    output logic              ep_tx,
    output logic              ep_wvalid,
    output logic [31:0]       ep_wdata,
    output logic [3:0]        ep_strb,
    input  logic              ep_wready,
    input  logic              ep_rvalid,
    input  logic [31:0]       ep_rdata,
    output logic              ep_rready
);

    mv_state_e        st;
    logic [4:0]       left;
    logic [3:0]       len_m1;

    ctrl_t            cur;
    logic [CNT_W-1:0] cur_cnt;
    logic             side_ok, fire, ok_beat, bad_beat;

    // burst size for the channel the arbiter offers
    logic [CNT_W:0]   g_words;
    logic [4:0]       g_bl, g_beats;

    assign g_words = ({1'b0, cnt_arr[gnt_idx]} + (CNT_W+1)'(3)) >> 2;
    assign g_bl    = burst_beats(ctrl_arr[gnt_idx].burst);
    assign g_beats = (g_words < (CNT_W+1)'(g_bl)) ? g_words[4:0] : g_bl;

    assign cur     = ctrl_arr[cur_ch];
    assign cur_cnt = cnt_arr[cur_ch];
    assign take    = (st == MV_IDLE) && any;

    assign beat_step = (cur_cnt >= CNT_W'(4)) ? 3'd4 : {1'b0, cur_cnt[1:0]};
    assign side_ok   = cur.tx ? ep_wready : ep_rvalid;
    assign mem_valid = (st == MV_BURST) && cur.en && (cur_cnt != '0) && side_ok;
    assign fire      = mem_valid && mem_ready;
    assign ok_beat   = fire && !mem_err;
    assign bad_beat  = fire && mem_err;

    always_comb begin
        beat_hit = '0;
        err_hit  = '0;
        beat_hit[cur_ch] = ok_beat;
        err_hit[cur_ch]  = bad_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MV_IDLE;
            cur_ch <= '0;
            left   <= '0;
            len_m1 <= '0;
        end else begin
            case (st)
                MV_IDLE: begin
                    if (any) begin
                        cur_ch <= gnt_idx;
                        left   <= g_beats;
                        len_m1 <= 4'(g_beats - 5'd1);
                        st     <= MV_BURST;
                    end
                end
                default: begin
                    if (!cur.en || cur_cnt == '0 || bad_beat ||
                        (ok_beat && left == 5'd1)) begin
                        st   <= MV_IDLE;
                        left <= '0;
                    end else if (ok_beat) begin
                        left <= left - 5'd1;
                    end
                end
            endcase
        end
    end

    assign mem_write = !cur.tx;
    assign mem_addr  = addr_arr[cur_ch];
    assign mem_strb  = strb_for(beat_step);
    assign mem_len   = len_m1;
    assign mem_burst = cur.burst;
    assign mem_wdata = ep_rdata;
    assign ep_num    = cur.ep;
    assign ep_tx     = cur.tx;
    assign ep_wvalid = ok_beat && cur.tx;
    assign ep_wdata  = mem_rdata;
    assign ep_strb   = mem_strb;
    assign ep_rready = ok_beat && !cur.tx;

    // R4: no beat beyond the length of the burst that was granted
    assert_burst_bound_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (left != 5'd0 && {1'b0, len_m1} >= left - 5'd1));

endmodule

// File: rtl/dma_ep_engine.sv
module dma_ep_engine
    import dma_ep_pkg::*;
#(
    parameter int          NCH      = 8,
    parameter int          ADDR_W   = 32,
    parameter int          CNT_W    = 17,
    parameter int          REG_AW   = 12,
    parameter logic [11:0] REG_BASE = 12'h200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_strb,
    output logic [3:0]        mem_len,
    output logic [1:0]        mem_burst,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic [3:0]        ep_num,
    output logic              ep_tx,
    output logic              ep_wvalid,
    output logic [31:0]       ep_wdata,
    output logic [3:0]        ep_strb,
    input  logic              ep_wready,
    input  logic              ep_rvalid,
    input  logic [31:0]       ep_rdata,
    output logic              ep_rready
);

    localparam int IDX_W = $clog2(NCH);
    localparam int WIN_LO = 4 + IDX_W;
    localparam logic [REG_AW-1:0] BASE_A = REG_AW'(REG_BASE);

    // register decode
    logic             in_win, rd_int;
    logic [IDX_W-1:0] sel;
    logic [3:0]       off;

    assign in_win = reg_addr[REG_AW-1:WIN_LO] == BASE_A[REG_AW-1:WIN_LO];
    assign sel    = reg_addr[WIN_LO-1:4];
    assign off    = reg_addr[3:0];
    assign rd_int = reg_re && (reg_addr == BASE_A);

    ctrl_t             ctrl_arr [NCH];
    logic [ADDR_W-1:0] addr_arr [NCH];
    logic [CNT_W-1:0]  cnt_arr  [NCH];
    logic [NCH-1:0]    req, flag_set, beat_hit, err_hit, gnt;
    logic [2:0]        beat_step;
    logic [IDX_W-1:0]  gnt_idx, cur_ch;
    logic              any, take;
    logic [NCH-1:0]    flags;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic hit;
        assign hit = in_win && (sel == IDX_W'(k)) && reg_we;
        dma_ep_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chan_i (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (hit && off == 4'h4),
            .wr_addr  (hit && off == 4'h8),
            .wr_cnt   (hit && off == 4'hC),
            .wdata    (reg_wdata),
            .beat_hit (beat_hit[k]),
            .beat_step(beat_step),
            .err_hit  (err_hit[k]),
            .ctrl     (ctrl_arr[k]),
            .addr     (addr_arr[k]),
            .cnt      (cnt_arr[k]),
            .req      (req[k]),
            .flag_set (flag_set[k])
        );
    end

    dma_ep_rr_arb #(.N(NCH)) arb_i (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .take   (take),
        .gnt    (gnt),
        .gnt_idx(gnt_idx),
        .any    (any)
    );

    dma_ep_mover #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) mover_i (
        .clk      (clk),
        .rst      (rst),
        .any      (any),
        .gnt_idx  (gnt_idx),
        .ctrl_arr (ctrl_arr),
        .addr_arr (addr_arr),
        .cnt_arr  (cnt_arr),
        .take     (take),
        .beat_hit (beat_hit),
        .beat_step(beat_step),
        .err_hit  (err_hit),
        .cur_ch   (cur_ch),
        .mem_valid(mem_valid),
        .mem_write(mem_write),
        .mem_addr (mem_addr),
        .mem_strb (mem_strb),
        .mem_len  (mem_len),
        .mem_burst(mem_burst),
        .mem_wdata(mem_wdata),
        .mem_ready(mem_ready),
        .mem_err  (mem_err),
        .mem_rdata(mem_rdata),
        .ep_num   (ep_num),
        .ep_tx    (ep_tx),
        .ep_wvalid(ep_wvalid),
        .ep_wdata (ep_wdata),
        .ep_strb  (ep_strb),
        .ep_wready(ep_wready),
        .ep_rvalid(ep_rvalid),
        .ep_rdata (ep_rdata),
        .ep_rready(ep_rready)
    );

    // interrupt flags: read clears what it returned, new events survive
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~(rd_int ? flags : '0)) | flag_set;
    end
    assign irq = |flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            reg_rdata <= '0;
            if (rd_int)
                reg_rdata <= 32'(flags);
            else if (in_win) begin
                case (off)
                    4'h4:    reg_rdata <= 32'(ctrl_arr[sel]);
                    4'h8:    reg_rdata <= 32'(addr_arr[sel]);
                    4'hC:    reg_rdata <= 32'(cnt_arr[sel]);
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    // R6: flags present at a status read are gone afterwards unless re-raised
    assert_int_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        rd_int |=> ((flags & $past(flags) & ~$past(flag_set)) == '0));

    // R8: a control write with enable clear silences that channel next cycle
    assert_abort_silences_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && in_win && off == 4'h4 && !reg_wdata[0])
            |=> !(mem_valid && cur_ch == $past(sel)));

endmodule

// File: tb/dma_ep_engine_tb_top.sv
module dma_ep_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_strb, mem_len;
    logic [1:0]  mem_burst;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  ep_num, ep_strb;
    logic        ep_tx, ep_wvalid, ep_rready;
    logic [31:0] ep_wdata;
    logic        ep_wready = 1'b0, ep_rvalid = 1'b0;
    logic [31:0] ep_rdata = '0;

    always #5 clk = ~clk;

    dma_ep_engine dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_strb(mem_strb), .mem_len(mem_len), .mem_burst(mem_burst),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .ep_num(ep_num), .ep_tx(ep_tx), .ep_wvalid(ep_wvalid),
        .ep_wdata(ep_wdata), .ep_strb(ep_strb), .ep_wready(ep_wready),
        .ep_rvalid(ep_rvalid), .ep_rdata(ep_rdata), .ep_rready(ep_rready)
    );

    int checks = 0, failures = 0;
    bit stall = 1'b0, err_arm = 1'b0;
    logic [31:0] err_addr = '0;

    // beat log
    int          nb = 0;
    logic [31:0] b_addr [0:4095];
    logic [3:0]  b_strb [0:4095];
    logic [3:0]  b_len  [0:4095];
    logic [3:0]  b_ep   [0:4095];
    logic [1:0]  b_bt   [0:4095];
    logic        b_wr   [0:4095];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37) ^ 32'h1234_5678;
    endfunction

    function automatic int beats_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // memory and endpoint models, driven just after each rising edge
    always @(posedge clk) begin
        #1;
        mem_ready = stall ? 1'b0 : ($urandom % 4 != 0);
        ep_wready = ($urandom % 5 != 0);
        ep_rvalid = ($urandom % 5 != 0);
        mem_rdata = pat(mem_addr);
        ep_rdata  = ~pat(mem_addr);
        mem_err   = err_arm && (mem_addr == err_addr);
    end

    // monitor on the falling edge
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (nb < 4096) begin
                b_addr[nb] = mem_addr; b_strb[nb] = mem_strb; b_len[nb] = mem_len;
                b_ep[nb] = ep_num; b_bt[nb] = mem_burst; b_wr[nb] = mem_write;
            end
            nb++;
            if (!mem_err) begin
                if (!mem_write)
                    chk(ep_wvalid && ep_wdata == pat(mem_addr) && ep_strb == mem_strb,
                        "R10 tx data to endpoint", ep_wdata, pat(mem_addr));
                else
                    chk(ep_rready && mem_wdata == ~pat(mem_addr),
                        "R10 rx data to memory", mem_wdata, ~pat(mem_addr));
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_re = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [11:0] ra(input int ch, input int o);
        return 12'(32'h200 + ch * 16 + o);
    endfunction

    function automatic logic [31:0] mk_ctrl(input int en, input int tx, input int ie,
                                            input int ep, input int bt);
        return 32'((bt << 9) | (ep << 4) | (ie << 3) | (tx << 1) | en);
    endfunction

    task automatic wait_idle(input int ch);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(ra(ch, 4), v);
            if (v[0] == 1'b0) return;
        end
        chk(1'b0, "R5 channel never finished", v, 0);
    endtask

    // run one transfer and compare the beat log with a computed list
    task automatic run_xfer(input int ch, input logic [31:0] a0, input int cnt,
                            input int bt, input int tx, input int ie);
        int base, words, bl, bad, bad_len;
        logic [31:0] v;
        base  = nb;
        words = (cnt + 3) / 4;
        bl    = beats_of(bt);
        wr(ra(ch, 8), a0);
        wr(ra(ch, 12), cnt);
        wr(ra(ch, 4), mk_ctrl(1, tx, ie, ch + 1, bt));
        wait_idle(ch);
        chk(nb - base == words, "R2 beat count", nb - base, words);
        chk(b_addr[base] == a0, "R2 first beat address", b_addr[base], a0);
        bad = 0; bad_len = 0;
        for (int w = 0; w < words; w++) begin
            int inb, rem;
            logic [3:0] es;
            inb = ((words - (w / bl) * bl) < bl) ? (words - (w / bl) * bl) : bl;
            rem = cnt - 4 * w;
            es  = (rem >= 4) ? 4'hF : (rem == 3) ? 4'h7 : (rem == 2) ? 4'h3 : 4'h1;
            if (b_addr[base + w] != a0 + 4 * w || b_strb[base + w] != es) bad++;
            if (b_len[base + w] != 4'(inb - 1) || b_bt[base + w] != 2'(bt)) bad_len++;
            if (b_ep[base + w] != 4'(ch + 1) || b_wr[base + w] != (tx == 0)) bad++;
        end
        chk(bad == 0, "R3 beat addresses and strobes", bad, 0);
        chk(bad_len == 0, "R4 burst length per beat", bad_len, 0);
        rd(ra(ch, 8), v);
        chk(v == a0 + cnt, "R3 address after transfer", v, a0 + cnt);
        rd(ra(ch, 12), v);
        chk(v == 0, "R3 count after transfer", v, 0);
        chk(irq == (ie != 0), "R6 irq level", irq, ie);
        rd(12'h200, v);
        chk(v == (ie ? (32'd1 << ch) : 0), "R5 flag follows interrupt enable", v,
            ie ? (32'd1 << ch) : 0);
        chk(irq == 1'b0, "R6 irq cleared after read", irq, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin : main
        logic [31:0] v;
        int snap, rseed;
        rseed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        rd(ra(0, 4), v);  chk(v == 0, "R1 reset control", v, 0);
        rd(12'h200, v);   chk(v == 0, "R6 reset status", v, 0);
        chk(irq == 0 && mem_valid == 0, "R2 idle after reset", {irq, mem_valid}, 0);

        // register readback; bit 8 dropped on write, enable left clear
        wr(ra(3, 4), 32'h0000_05AE);
        rd(ra(3, 4), v);  chk(v == 32'h4AE, "R1 control readback", v, 32'h4AE);
        wr(ra(3, 8), 32'hDEAD_BEE0);
        rd(ra(3, 8), v);  chk(v == 32'hDEAD_BEE0, "R1 address readback", v, 32'hDEAD_BEE0);
        wr(ra(3, 12), 32'hFFFF_FFFF);
        rd(ra(3, 12), v); chk(v == 32'h1_FFFF, "R11 count width", v, 32'h1_FFFF);
        wr(ra(3, 12), 0);

        // directed transfers
        run_xfer(0, 32'h1000, 10, 1, 1, 1);   // partial last word
        run_xfer(4, 32'h2000, 40, 2, 1, 1);   // 8 + shortened 2
        run_xfer(6, 32'h3000, 100, 3, 1, 0);  // 16 + 9, no flag
        run_xfer(5, 32'h3800, 13, 0, 0, 0);   // receive, single beats
        run_xfer(7, 32'h3900, 3, 2, 0, 1);    // receive, one partial beat

        // R7: bus error on the third beat
        err_addr = 32'h4008; err_arm = 1'b1;
        snap = nb;
        wr(ra(2, 8), 32'h4000);
        wr(ra(2, 12), 64);
        wr(ra(2, 4), mk_ctrl(1, 1, 0, 3, 1));
        wait_idle(2);
        repeat (20) @(posedge clk);
        err_arm = 1'b0;
        chk(nb - snap == 3, "R7 no beats after error", nb - snap, 3);
        rd(ra(2, 4), v);
        chk(v[8] == 1'b1 && v[0] == 1'b0, "R7 error bit set, enable clear", v, 32'h100);
        rd(ra(2, 8), v);
        chk(v == 32'h4008, "R7 error beat not counted", v, 32'h4008);
        chk(irq == 1'b1, "R7 irq despite interrupt enable clear", irq, 1);
        rd(12'h200, v);
        chk(v == 32'h4, "R7 flag of errored channel", v, 32'h4);

        // R8: abort a long transfer while running
        wr(ra(1, 8), 32'h8000);
        wr(ra(1, 12), 32'h1_0000);
        wr(ra(1, 4), mk_ctrl(1, 1, 1, 2, 3));
        repeat (40) @(posedge clk);
        wr(ra(1, 4), 0);
        snap = nb;
        wr(ra(1, 8), 0);
        wr(ra(1, 12), 0);
        repeat (30) @(posedge clk);
        chk(snap > 0 && nb == snap, "R8 no beats after abort", nb, snap);
        rd(ra(1, 4), v);  chk(v == 0, "R8 control idle", v, 0);
        rd(ra(1, 12), v); chk(v == 0, "R8 count cleared", v, 0);
        rd(12'h200, v);   chk(v == 0, "R8 no flag after abort", v, 0);

        // R9: three channels waiting together
        stall = 1'b1;
        snap = nb;
        for (int c = 0; c < 3; c++) begin
            wr(ra(c, 8), 32'h9000 + c * 32'h100);
            wr(ra(c, 12), 32);
            wr(ra(c, 4), mk_ctrl(1, 1, 0, c + 1, 1));
        end
        repeat (5) @(posedge clk);
        stall = 1'b0;
        wait_idle(0); wait_idle(1); wait_idle(2);
        begin
            int bad;
            bad = 0;
            for (int j = 0; j < 24; j++)
                if (b_ep[snap + j] != 4'(((j / 4) % 3) + 1)) bad++;
            chk(nb - snap == 24 && bad == 0, "R9 round-robin burst order", bad, 0);
        end

        // random single-channel transfers
        for (int it = 0; it < 8; it++) begin
            int c, n, t, d, e;
            c = $urandom % 8;
            n = 1 + ($urandom % 70);
            t = $urandom % 4;
            d = $urandom % 2;
            e = $urandom % 2;
            run_xfer(c, 32'h10000 + ($urandom % 256) * 4, n, t, d, e);
        end

        report();
    end

endmodule